// File: doc/BRIEF.md
# Host Bridge Control Register Bank

This block is the word-wide control and status register bank of a host bridge. A single memory-mapped request port carries a byte offset into the bridge region, a write flag and write data. Reads answer one cycle later on a response port. The bank holds 28 word registers. They cover power-on and general configuration, I/O and SDRAM setup, PCI address mapping, GPIO, interrupt routing configuration, four mailboxes, PCI cache control and timing. Most of them are plain storage for neighbouring blocks that are not part of this design.

Three behaviours go beyond plain storage. The interrupt enable word can be changed only through a write-one-to-set alias and a write-one-to-clear alias. The enable word itself and the interrupt status word are read-only. A write that moves one bit of the general configuration word from 0 to 1 raises a one-cycle system reset request. The bank drives the interrupt edge-select, polarity and enable words out as ports, together with the PCI configuration map word, so that the interrupt and configuration logic can use them directly.

Top module: `brg_ctl_regs`

## Requirements
- R1: After reset, the registers hold the following values, and every other register holds 0:
  - 0x100 (power-on config): 0x00000C40
  - 0x104 (general config): 0x00001384
  - 0x108 (I/O device config): 0x2BFF8010
  - 0x10C (SDRAM config): 0x255E0091
  - 0x110 (PCI map): 0x00006140
  - 0x11C (GPIO data): 0x000001FF
  - 0x120 (GPIO input enable): 0x000001FF
  - 0x168 (DQ config): 0x00000008
  - 0x16C (memory size): 0x10000000
- R2: The register window spans byte offsets 0x100 to 0x16F, and register index = (offset − 0x100) >> 2. A write to any storage register other than 0x130, 0x134, 0x138 and 0x13C stores the full 32-bit word, and a later read of that offset returns it.
- R3: A write to the enable-set alias at 0x130 stores the written word at 0x130. It also ORs that word into the enable register at 0x138.
- R4: A write to the enable-clear alias at 0x134 stores the written word at 0x134. It also clears in 0x138 every bit that is 1 in the written word.
- R5: Writes to the enable register at 0x138 and to the interrupt status register at 0x13C change nothing: neither the read-back values nor `int_en_o`. The status register reads 0.
- R6: A write to 0x104 raises `sys_reset_req` for exactly one cycle, in the cycle after the write, when bit 2 of the stored word is 0 and bit 2 of the written word is 1. No other write raises it. The word is stored in every case.
- R7: An offset below 0x100, an offset at or above 0x170, and an offset whose two low bits are not 00 all fall outside the window. A write there changes no register, and a read there returns 0.
- R8: `int_edge_o`, `int_pol_o`, `int_en_o` and `cfg_map_o` show the registers at 0x124, 0x12C, 0x138 and 0x118. Each one takes a new value in the cycle after the write that changes it, and at no other time.
- R9: A read request accepted at a clock edge gives `rsp_valid` = 1 for the following cycle, with the word in `rsp_rdata`. Back-to-back reads answer on consecutive cycles. When there is no read, `rsp_valid` is 0 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the bridge region |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data, 0 when not valid |
| sys_reset_req | output | 1 | One-cycle system reset request |
| int_edge_o | output | 32 | Interrupt edge-select word (0x124) |
| int_pol_o | output | 32 | Interrupt polarity word (0x12C) |
| int_en_o | output | 32 | Interrupt enable word (0x138) |
| cfg_map_o | output | 32 | PCI configuration map word (0x118) |

## Verification
Storage is tried with all-ones, all-zeros, alternating and single-bit words, so that a stuck bit or a shifted index shows up as a wrong read-back. The enable aliases get overlapping set and clear masks, which separates OR, AND-NOT and plain overwrite. The general configuration word is written 1→1, 1→0 and 0→1 on bit 2, so that only a true rising edge produces the reset pulse. Accesses below, above and beside the window, and misaligned ones, show whether any register leaks through the decode.

// File: rtl/brg_ctl_pkg.sv
package brg_ctl_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 28;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int WIN_BASE = 'h100;

    typedef logic [DATA_W-1:0] word_t;

    // Register indices; offsets are software visible
    localparam int IX_PWRON    = 0;
    localparam int IX_GENCFG   = 1;
    localparam int IX_IODEV    = 2;
    localparam int IX_SDRAM    = 3;
    localparam int IX_PCIMAP   = 4;
    localparam int IX_MEMBASE  = 5;
    localparam int IX_CFGMAP   = 6;
    localparam int IX_GPIO_DAT = 7;
    localparam int IX_GPIO_IE  = 8;
    localparam int IX_EDGE     = 9;
    localparam int IX_STEER    = 10;
    localparam int IX_POL      = 11;
    localparam int IX_ENSET    = 12;
    localparam int IX_ENCLR    = 13;
    localparam int IX_EN       = 14;
    localparam int IX_STAT     = 15;
    localparam int IX_DQ       = 26;
    localparam int IX_MSIZE    = 27;

    localparam int GEN_RST_BIT = 2;

    typedef enum logic [1:0] {
        WK_PLAIN,
        WK_SET,
        WK_CLR,
        WK_RO
    } wkind_e;

    function automatic word_t reset_word(input int idx);
        word_t w;
        case (idx)
            IX_PWRON:    w = 32'h0000_0C40;
            IX_GENCFG:   w = 32'h0000_1384;
            IX_IODEV:    w = 32'h2BFF_8010;
            IX_SDRAM:    w = 32'h255E_0091;
            IX_PCIMAP:   w = 32'h0000_6140;
            IX_GPIO_DAT: w = 32'h0000_01FF;
            IX_GPIO_IE:  w = 32'h0000_01FF;
            IX_DQ:       w = 32'h0000_0008;
            IX_MSIZE:    w = 32'h1000_0000;
            default:     w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/brg_addr_dec.sv
module brg_addr_dec
    import brg_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output wkind_e            kind
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(WIN_BASE);
    localparam logic [ADDR_W-1:0] NREG_A = ADDR_W'(NUM_REGS);

    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] word_no;
    logic              aligned;
    logic              above;

    always_comb begin
        off     = addr - BASE_A;
        word_no = off >> 2;
        aligned = (addr[1:0] == 2'b00);
        above   = (addr >= BASE_A);
        hit     = aligned && above && (word_no < NREG_A);
        idx     = word_no[IDX_W-1:0];
    end

    always_comb begin
        if (idx == IDX_W'(IX_ENSET)) begin
            kind = WK_SET;
        end else if (idx == IDX_W'(IX_ENCLR)) begin
            kind = WK_CLR;
        end else if (idx == IDX_W'(IX_EN) || idx == IDX_W'(IX_STAT)) begin
            kind = WK_RO;
        end else begin
            kind = WK_PLAIN;
        end
    end

endmodule

// File: rtl/brg_en_update.sv
module brg_en_update
    import brg_ctl_pkg::*;
(
    input  word_t en_q,
    input  word_t wdata,
    input  logic  do_set,
    input  logic  do_clr,
    output word_t en_d
);

    always_comb begin
        en_d = en_q;
        if (do_set) begin
            en_d = en_q | wdata;
        end else if (do_clr) begin
            en_d = en_q & ~wdata;
        end
    end

endmodule

// File: rtl/brg_rst_edge.sv
module brg_rst_edge (
    input  logic wr_gen,
    input  logic old_bit,
    input  logic new_bit,
    output logic fire
);

    always_comb begin
        fire = wr_gen && !old_bit && new_bit;
    end

endmodule

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs
    import brg_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              sys_reset_req,
    output logic [31:0]       int_edge_o,
    output logic [31:0]       int_pol_o,
    output logic [31:0]       int_en_o,
    output logic [31:0]       cfg_map_o
);

    typedef struct packed {
        word_t [NUM_REGS-1:0] regs;
        logic                 rsp_valid;
        word_t                rsp_rdata;
        logic                 rst_req;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            s.regs[i] = reset_word(i);
        end
        return s;
    endfunction

    localparam state_t RST_STATE = reset_state();

    state_t st_d;
    state_t st_q;

    logic             hit;
    logic [IDX_W-1:0] idx;
    wkind_e           kind;
    logic             wr_hit;
    logic             rd_req;
    word_t            rd_word;
    word_t            en_next;
    logic             gen_wr;
    logic             rst_fire;

    brg_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .hit  (hit),
        .idx  (idx),
        .kind (kind)
    );

    always_comb begin
        wr_hit = req_valid && req_write && hit;
        rd_req = req_valid && !req_write;
        gen_wr = wr_hit && (idx == IDX_W'(IX_GENCFG));
    end

    brg_en_update u_en (
        .en_q   (st_q.regs[IX_EN]),
        .wdata  (req_wdata),
        .do_set (wr_hit && (kind == WK_SET)),
        .do_clr (wr_hit && (kind == WK_CLR)),
        .en_d   (en_next)
    );

    brg_rst_edge u_edge (
        .wr_gen  (gen_wr),
        .old_bit (st_q.regs[IX_GENCFG][GEN_RST_BIT]),
        .new_bit (req_wdata[GEN_RST_BIT]),
        .fire    (rst_fire)
    );

    // Read mux built from an index compare per register
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit && (idx == IDX_W'(i))) begin
                rd_word = st_q.regs[i];
            end
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = rd_req;
        st_d.rsp_rdata = rd_req ? rd_word : '0;
        st_d.rst_req   = rst_fire;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_hit && (idx == IDX_W'(i)) && (kind != WK_RO)) begin
                st_d.regs[i] = req_wdata;
            end
        end
        st_d.regs[IX_EN] = en_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rsp_valid     = st_q.rsp_valid;
        rsp_rdata     = st_q.rsp_rdata;
        sys_reset_req = st_q.rst_req;
        int_edge_o    = st_q.regs[IX_EDGE];
        int_pol_o     = st_q.regs[IX_POL];
        int_en_o      = st_q.regs[IX_EN];
        cfg_map_o     = st_q.regs[IX_CFGMAP];
    end

endmodule

// File: rtl/brg_ctl_regs_chk.sv
module brg_ctl_regs_chk
    import brg_ctl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              sys_reset_req,
    input logic [31:0]       int_edge_o,
    input logic [31:0]       int_pol_o,
    input logic [31:0]       int_en_o,
    input logic [31:0]       cfg_map_o
);

    localparam logic [ADDR_W-1:0] A_GEN   = ADDR_W'(WIN_BASE + 4 * IX_GENCFG);
    localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(WIN_BASE + 4 * IX_ENSET);
    localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(WIN_BASE + 4 * IX_ENCLR);
    localparam logic [ADDR_W-1:0] A_EDGE  = ADDR_W'(WIN_BASE + 4 * IX_EDGE);
    localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(WIN_BASE + 4 * IX_POL);
    localparam logic [ADDR_W-1:0] A_MAP   = ADDR_W'(WIN_BASE + 4 * IX_CFGMAP);

    logic wr;
    assign wr = req_valid && req_write;

    // R9
    a_r9_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
    a_r9_idle_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0));

    // R6
    a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);
    a_r6_pulse_needs_gen_write: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(wr && (req_addr == A_GEN) && req_wdata[GEN_RST_BIT]));

    // R3
    a_r3_set_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (req_addr == A_ENSET)) |=> ((int_en_o & $past(req_wdata)) == $past(req_wdata)));
    // R4
    a_r4_clr_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (req_addr == A_ENCLR)) |=> ((int_en_o & $past(req_wdata)) == '0));

    // R5 and R8: enable moves only through the aliases
    a_r5_en_only_via_alias: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && ((req_addr == A_ENSET) || (req_addr == A_ENCLR))) |=> $stable(int_en_o));

    // R8
    a_r8_edge_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (req_addr == A_EDGE)) |=> $stable(int_edge_o));
    a_r8_pol_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (req_addr == A_POL)) |=> $stable(int_pol_o));
    a_r8_map_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (req_addr == A_MAP)) |=> $stable(cfg_map_o));

endmodule

bind brg_ctl_regs brg_ctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_brg_ctl_regs.sv
module tb_brg_ctl_regs;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          sys_reset_req;
    logic [31:0]   int_edge_o;
    logic [31:0]   int_pol_o;
    logic [31:0]   int_en_o;
    logic [31:0]   cfg_map_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] model [28];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    brg_ctl_regs #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .sys_reset_req(sys_reset_req),
        .int_edge_o(int_edge_o), .int_pol_o(int_pol_o), .int_en_o(int_en_o),
        .cfg_map_o(cfg_map_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_win(input logic [AW-1:0] a);
        return (a[1:0] == 2'b00) && (a >= 12'h100) && (a < 12'h170);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 28; i++) model[i] = 32'h0;
        model[0]  = 32'h0000_0C40;
        model[1]  = 32'h0000_1384;
        model[2]  = 32'h2BFF_8010;
        model[3]  = 32'h255E_0091;
        model[4]  = 32'h0000_6140;
        model[7]  = 32'h0000_01FF;
        model[8]  = 32'h0000_01FF;
        model[26] = 32'h0000_0008;
        model[27] = 32'h1000_0000;
    endfunction

    // Monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R9 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        int  idx;
        bit  pulse;
        pulse = 1'b0;
        if (in_win(a)) begin
            idx = int'((a - 12'h100) >> 2);
            case (idx)
                1: begin
                    pulse = !model[1][2] && d[2];
                    model[1] = d;
                end
                12: begin model[12] = d; model[14] = model[14] | d; end
                13: begin model[13] = d; model[14] = model[14] & ~d; end
                14, 15: ;
                default: model[idx] = d;
            endcase
        end
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R6 reset pulse", {31'h0, sys_reset_req}, {31'h0, pulse});
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        logic [31:0] e;
        e = in_win(a) ? model[int'((a - 12'h100) >> 2)] : 32'h0;
        exp_q.push_back(e);
        tag_q.push_back(req);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 int_en_o", int_en_o, 32'h0);
        check("R1 cfg_map_o", cfg_map_o, 32'h0);
        check("R1 sys_reset_req", {31'h0, sys_reset_req}, 32'h0);
        check("R9 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
        for (int i = 0; i < 28; i++) do_read(AW'(12'h100 + 4 * i), "R1 reset value");
        idle(2);

        // R2 plain storage, several patterns
        do_write(12'h100, 32'hA5A5_5A5A);
        do_write(12'h140, 32'hFFFF_FFFF);
        do_write(12'h14C, 32'h0000_0001);
        do_write(12'h16C, 32'h8000_0000);
        do_write(12'h11C, 32'h0000_0000);
        do_read(12'h100, "R2 readback");
        do_read(12'h140, "R2 readback");
        do_read(12'h14C, "R2 readback");
        do_read(12'h16C, "R2 readback");
        do_read(12'h11C, "R2 readback");
        idle(2);

        // R8 exported words
        do_write(12'h124, 32'h0000_00F5);
        check("R8 int_edge_o", int_edge_o, 32'h0000_00F5);
        do_write(12'h12C, 32'h3C00_0003);
        check("R8 int_pol_o", int_pol_o, 32'h3C00_0003);
        do_write(12'h118, 32'h0001_8000);
        check("R8 cfg_map_o", cfg_map_o, 32'h0001_8000);
        check("R8 int_edge_o held", int_edge_o, 32'h0000_00F5);

        // R3 enable set alias
        do_write(12'h130, 32'h0000_00F0);
        check("R3 int_en_o", int_en_o, 32'h0000_00F0);
        do_write(12'h130, 32'h0F00_000F);
        check("R3 int_en_o or", int_en_o, 32'h0F00_00FF);
        do_read(12'h130, "R3 set alias stored");
        do_read(12'h138, "R3 enable readback");

        // R4 enable clear alias
        do_write(12'h134, 32'h0000_00F3);
        check("R4 int_en_o", int_en_o, 32'h0F00_000C);
        do_read(12'h134, "R4 clear alias stored");
        do_read(12'h138, "R4 enable readback");

        // R5 read-only words
        do_write(12'h138, 32'hFFFF_FFFF);
        check("R5 int_en_o unchanged", int_en_o, 32'h0F00_000C);
        do_write(12'h13C, 32'h0000_1234);
        do_read(12'h138, "R5 enable unchanged");
        do_read(12'h13C, "R5 status reads 0");

        // R6 reset request edge
        do_write(12'h104, 32'h0000_1384);
        do_write(12'h104, 32'h0000_0000);
        do_write(12'h104, 32'h0000_0004);
        @(negedge clk);
        check("R6 pulse ends", {31'h0, sys_reset_req}, 32'h0);
        do_write(12'h104, 32'hFFFF_FFFF);
        do_read(12'h104, "R6 value stored");

        // R7 outside the window
        do_write(12'h170, 32'hDEAD_BEEF);
        do_write(12'h0FC, 32'hDEAD_BEEF);
        do_write(12'h101, 32'hDEAD_BEEF);
        do_write(12'h13A, 32'hFFFF_FFFF);
        check("R7 int_en_o untouched", int_en_o, 32'h0F00_000C);
        do_read(12'h170, "R7 read above");
        do_read(12'h0FC, "R7 read below");
        do_read(12'h102, "R7 read misaligned");
        do_read(12'h100, "R7 in-window untouched");
        do_read(12'h16C, "R7 last word untouched");

        // R9 idle after back-to-back reads
        idle(1);
        check("R9 idle rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R9 idle rsp_rdata", rsp_rdata, 32'h0);
        check("R9 queue drained", 32'(exp_q.size()), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule